// File: doc/BRIEF.md
# Memory Operand Segment Selector

This block decides which segment register an instruction's memory operand goes through. It looks at the prefix bytes of the instruction and at its one-byte primary opcode, which tells whether the instruction is a string operation. It also takes the register that anchors the operand address, the address size and whether the core runs in 64-bit mode. From these it produces a 3-bit segment index and an error flag. A decode or fault-handling path uses the index to fetch a selector and descriptor. Those steps are outside this block.

The inputs are sampled on each rising clock edge, and the result is held in an output register. The block first handles a few special cases. An instruction-pointer-relative reference never examines prefixes. The destination index of a string instruction cannot be overridden. Otherwise the block looks for a single segment-override prefix, and when there is none it uses the operand register's default segment. In 64-bit mode, FS and GS are the only overrides that survive. Every other outcome becomes "ignore".

Top module: `seg_resolver`

## Requirements
- R1: The outputs are registered. A result shows at `seg_idx`/`seg_err` one clock after its inputs are sampled. While `rst` is high, the outputs hold index 6 with `seg_err` low.
- R2: Segment index codes: 0=CS, 1=SS, 2=DS, 3=ES, 4=FS, 5=GS, 6=ignore. Override prefix bytes map 0x2E to CS, 0x36 to SS, 0x3E to DS, 0x26 to ES, 0x64 to FS and 0x65 to GS. Outside 64-bit mode, a single valid override sets the result to its segment, whatever the operand register.
- R3: Two or more valid override prefix slots raise `seg_err`, and this includes the same byte repeated. Whenever `seg_err` is high, `seg_idx` is 7. This rule applies only where prefixes are examined (see R5 and R8).
- R4: A slot whose `pfx_valid` bit is low has no effect, whatever its byte. A valid byte that is not an override (such as 0x66, 0xF3, 0xF0) also has no effect. Slot s occupies `pfx_bytes[8s+7:8s]`.
- R5: An instruction is a string operation when `opcode_single` is high and `opcode` lies in 0x6C–0x6F, 0xA4–0xA7 or 0xAA–0xAF. For such an instruction with operand register DI, prefixes are not examined and the result is ES (ignore in 64-bit mode). This holds even when several overrides are present.
- R6: With no override and outside 64-bit mode, register codes B, SI and "none" give DS. DI on a non-string instruction also gives DS.
- R7: With no override and outside 64-bit mode, SP and BP give SS.
- R8: When the operand register code is IP, the result is CS, or ignore in 64-bit mode. `seg_err` stays low and prefixes are not examined.
- R9: With no override and outside 64-bit mode, registers A, C and D raise `seg_err` when `addr_size` is 0 (2 bytes). With `addr_size` 1 (4 bytes) or 2 (8 bytes) they give DS.
- R10: In 64-bit mode, having no override gives ignore for every register code. A single FS or GS override keeps its index, and any other single override gives ignore.
- R11: Register codes are 0=A, 1=C, 2=D, 3=B, 4=SP, 5=BP, 6=SI, 7=DI, 8–15 extended registers, 16=none and 17=IP. Outside 64-bit mode with no override, the codes 8–15 and 18–31 raise `seg_err`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pfx_bytes | input | 32 | Four prefix byte slots, slot 0 in bits 7:0 |
| pfx_valid | input | 4 | One valid bit for each prefix slot |
| opcode | input | 8 | First primary opcode byte |
| opcode_single | input | 1 | High when the primary opcode is one byte long |
| op_reg | input | 5 | Operand anchor register code (see R11) |
| addr_size | input | 2 | 0=2 bytes, 1=4 bytes, 2=8 bytes |
| mode64 | input | 1 | Core is in 64-bit mode |
| seg_idx | output | 3 | Resolved segment index, 7 on error |
| seg_err | output | 1 | Resolution error |

## Verification
The hardest cases to reach are the ones where one rule overrides another. A DI operand on a string instruction must ignore a pair of overrides that would otherwise raise an error. An IP operand must skip prefixes entirely. A 16-bit A/C/D operand escapes its error only because an override is present. The stimulus reaches all of these by sweeping the full product of every register code, both modes, every address size, string and non-string opcodes, and ten prefix layouts. The layouts include a repeated override, an override hidden in an invalid slot and an override placed in each slot position. Each result is compared against a model built from the rules alone.

// File: rtl/seg_res_pkg.sv
package seg_res_pkg;

    localparam int PFX_SLOTS = 4;
    localparam int REG_W     = 5;
    localparam int IDX_W     = 3;

    typedef enum logic [IDX_W-1:0] {
        SEG_CS  = 3'd0,
        SEG_SS  = 3'd1,
        SEG_DS  = 3'd2,
        SEG_ES  = 3'd3,
        SEG_FS  = 3'd4,
        SEG_GS  = 3'd5,
        SEG_IGN = 3'd6,
        SEG_BAD = 3'd7
    } seg_idx_e;

    // operand anchor register codes
    localparam logic [REG_W-1:0] RC_A    = 5'd0;
    localparam logic [REG_W-1:0] RC_C    = 5'd1;
    localparam logic [REG_W-1:0] RC_D    = 5'd2;
    localparam logic [REG_W-1:0] RC_B    = 5'd3;
    localparam logic [REG_W-1:0] RC_SP   = 5'd4;
    localparam logic [REG_W-1:0] RC_BP   = 5'd5;
    localparam logic [REG_W-1:0] RC_SI   = 5'd6;
    localparam logic [REG_W-1:0] RC_DI   = 5'd7;
    localparam logic [REG_W-1:0] RC_NONE = 5'd16;
    localparam logic [REG_W-1:0] RC_IP   = 5'd17;

    localparam logic [1:0] ASZ_16 = 2'd0;

    typedef struct packed {
        logic     hit;
        seg_idx_e idx;
    } ovr_t;

    typedef struct packed {
        logic     err;
        seg_idx_e idx;
    } seg_res_t;

    function automatic ovr_t decode_pfx(input logic [7:0] b);
        ovr_t o;
        o.hit = 1'b1;
        o.idx = SEG_IGN;
        case (b)
            8'h2E:   o.idx = SEG_CS;
            8'h36:   o.idx = SEG_SS;
            8'h3E:   o.idx = SEG_DS;
            8'h26:   o.idx = SEG_ES;
            8'h64:   o.idx = SEG_FS;
            8'h65:   o.idx = SEG_GS;
            default: o.hit = 1'b0;
        endcase
        return o;
    endfunction

    function automatic logic is_string_op(input logic [7:0] opc, input logic single);
        logic in_rng;
        in_rng = (opc >= 8'h6C && opc <= 8'h6F) ||
                 (opc >= 8'hA4 && opc <= 8'hA7) ||
                 (opc >= 8'hAA && opc <= 8'hAF);
        return single && in_rng;
    endfunction

    function automatic seg_res_t ok_res(input seg_idx_e i);
        seg_res_t r;
        r.err = 1'b0;
        r.idx = i;
        return r;
    endfunction

    function automatic seg_res_t bad_res();
        seg_res_t r;
        r.err = 1'b1;
        r.idx = SEG_BAD;
        return r;
    endfunction

endpackage

// File: rtl/seg_pfx_scan.sv
module seg_pfx_scan
    import seg_res_pkg::*;
#(
    parameter int SLOTS = PFX_SLOTS
) (
    input  logic [8*SLOTS-1:0] bytes_i,
    input  logic [SLOTS-1:0]   valid_i,
    output logic               any_o,
    output logic               multi_o,
    output seg_idx_e           idx_o
);
    localparam int CNT_W = $clog2(SLOTS + 1);

    logic     [SLOTS-1:0] hit;
    seg_idx_e             slot_idx [SLOTS];

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        ovr_t dec;
        assign dec         = decode_pfx(bytes_i[8*s +: 8]);
        assign hit[s]      = dec.hit && valid_i[s];
        assign slot_idx[s] = dec.idx;
    end

    logic [CNT_W-1:0] cnt;

    always_comb begin
        cnt   = '0;
        idx_o = SEG_IGN;
        for (int s = 0; s < SLOTS; s++) begin
            if (hit[s]) begin
                cnt   = cnt + 1'b1;
                idx_o = slot_idx[s];
            end
        end
        any_o   = (cnt != '0);
        multi_o = (cnt > CNT_W'(1));
    end

endmodule

// File: rtl/seg_dflt_sel.sv
module seg_dflt_sel
    import seg_res_pkg::*;
(
    input  logic [REG_W-1:0] reg_i,
    input  logic [1:0]       asz_i,
    input  logic             str_i,
    input  logic             m64_i,
    output seg_res_t         res_o
);
    always_comb begin
        if (m64_i) begin
            res_o = ok_res(SEG_IGN);
        end else begin
            case (reg_i)
                RC_A, RC_C, RC_D:
                    res_o = (asz_i == ASZ_16) ? bad_res() : ok_res(SEG_DS);
                RC_B, RC_SI, RC_NONE:
                    res_o = ok_res(SEG_DS);
                RC_DI:
                    res_o = ok_res(str_i ? SEG_ES : SEG_DS);
                RC_SP, RC_BP:
                    res_o = ok_res(SEG_SS);
                RC_IP:
                    res_o = ok_res(SEG_CS);
                default:
                    res_o = bad_res();
            endcase
        end
    end

endmodule

// File: rtl/seg_resolver.sv
module seg_resolver
    import seg_res_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic [8*PFX_SLOTS-1:0] pfx_bytes,
    input  logic [PFX_SLOTS-1:0]   pfx_valid,
    input  logic [7:0]             opcode,
    input  logic                   opcode_single,
    input  logic [REG_W-1:0]       op_reg,
    input  logic [1:0]             addr_size,
    input  logic                   mode64,
    output logic [IDX_W-1:0]       seg_idx,
    output logic                   seg_err
);
    logic     ovr_any, ovr_multi, str_op;
    seg_idx_e ovr_idx;
    seg_res_t dflt, nxt, q;

    assign str_op = is_string_op(opcode, opcode_single);

    seg_pfx_scan #(.SLOTS(PFX_SLOTS)) u_scan (
        .bytes_i (pfx_bytes),
        .valid_i (pfx_valid),
        .any_o   (ovr_any),
        .multi_o (ovr_multi),
        .idx_o   (ovr_idx)
    );

    seg_dflt_sel u_dflt (
        .reg_i (op_reg),
        .asz_i (addr_size),
        .str_i (str_op),
        .m64_i (mode64),
        .res_o (dflt)
    );

    always_comb begin
        if (op_reg == RC_IP) begin
            nxt = ok_res(mode64 ? SEG_IGN : SEG_CS);
        end else if (op_reg == RC_DI && str_op) begin
            nxt = dflt;
        end else if (ovr_multi) begin
            nxt = bad_res();
        end else if (ovr_any) begin
            if (mode64 && ovr_idx != SEG_FS && ovr_idx != SEG_GS)
                nxt = ok_res(SEG_IGN);
            else
                nxt = ok_res(ovr_idx);
        end else begin
            nxt = dflt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= ok_res(SEG_IGN);
        else     q <= nxt;
    end

    assign seg_idx = q.idx;
    assign seg_err = q.err;

endmodule

// File: rtl/seg_resolver_chk.sv
module seg_resolver_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] pfx_bytes,
    input logic [3:0]  pfx_valid,
    input logic [7:0]  opcode,
    input logic        opcode_single,
    input logic [4:0]  op_reg,
    input logic [1:0]  addr_size,
    input logic        mode64,
    input logic [2:0]  seg_idx,
    input logic        seg_err
);
    logic str_in;
    assign str_in = opcode_single &&
        ((opcode >= 8'h6C && opcode <= 8'h6F) ||
         (opcode >= 8'hA4 && opcode <= 8'hA7) ||
         (opcode >= 8'hAA && opcode <= 8'hAF));

    AST_ERR_IDX_SEVEN: assert property (@(posedge clk) disable iff (rst)
        seg_err |-> seg_idx == 3'd7); // R3

    AST_IP_CS: assert property (@(posedge clk) disable iff (rst)
        (op_reg == 5'd17 && !mode64) |=> (seg_idx == 3'd0 && !seg_err)); // R8

    AST_IP_IGNORE: assert property (@(posedge clk) disable iff (rst)
        (op_reg == 5'd17 && mode64) |=> (seg_idx == 3'd6 && !seg_err)); // R8

    AST_LONG_MODE_SET: assert property (@(posedge clk) disable iff (rst)
        mode64 |=> (seg_err || seg_idx == 3'd4 || seg_idx == 3'd5 || seg_idx == 3'd6)); // R10

    AST_STACK_SS: assert property (@(posedge clk) disable iff (rst)
        (!mode64 && pfx_valid == 4'd0 && (op_reg == 5'd4 || op_reg == 5'd5))
        |=> (seg_idx == 3'd1 && !seg_err)); // R7

    AST_STRING_DI_ES: assert property (@(posedge clk) disable iff (rst)
        (!mode64 && op_reg == 5'd7 && str_in) |=> (seg_idx == 3'd3 && !seg_err)); // R5

    AST_NARROW_ADC_ERR: assert property (@(posedge clk) disable iff (rst)
        (!mode64 && pfx_valid == 4'd0 && op_reg <= 5'd2 && addr_size == 2'd0)
        |=> seg_err); // R9

endmodule

bind seg_resolver seg_resolver_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .pfx_bytes     (pfx_bytes),
    .pfx_valid     (pfx_valid),
    .opcode        (opcode),
    .opcode_single (opcode_single),
    .op_reg        (op_reg),
    .addr_size     (addr_size),
    .mode64        (mode64),
    .seg_idx       (seg_idx),
    .seg_err       (seg_err)
);

// File: tb/seg_resolver_test.sv
module seg_resolver_test;
    localparam time CLK_P = 8ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] pfx_bytes = '0;
    logic [3:0]  pfx_valid = '0;
    logic [7:0]  opcode = '0;
    logic        opcode_single = 1'b0;
    logic [4:0]  op_reg = '0;
    logic [1:0]  addr_size = '0;
    logic        mode64 = 1'b0;
    logic [2:0]  seg_idx;
    logic        seg_err;

    int unsigned checks = 0;
    int unsigned failures = 0;
    bit          finished = 1'b0;

    logic [3:0] exp_q [$];
    string      tag_q [$];

    always #(CLK_P/2) clk = ~clk;

    seg_resolver uut (
        .clk(clk), .rst(rst), .pfx_bytes(pfx_bytes), .pfx_valid(pfx_valid),
        .opcode(opcode), .opcode_single(opcode_single), .op_reg(op_reg),
        .addr_size(addr_size), .mode64(mode64), .seg_idx(seg_idx), .seg_err(seg_err)
    );

    function automatic int ovr_code(input logic [7:0] b);
        case (b)
            8'h2E: return 0;
            8'h36: return 1;
            8'h3E: return 2;
            8'h26: return 3;
            8'h64: return 4;
            8'h65: return 5;
            default: return -1;
        endcase
    endfunction

    // expected result from the requirements: {err, idx}
    function automatic logic [3:0] model(input logic [31:0] pb, input logic [3:0] pv,
                                         input logic [7:0] opc, input logic one,
                                         input int rc, input int asz, input logic m64,
                                         output string tag);
        logic str;
        int   n, o;
        str = one && ((opc >= 8'h6C && opc <= 8'h6F) || (opc >= 8'hA4 && opc <= 8'hA7) ||
                      (opc >= 8'hAA && opc <= 8'hAF));
        if (rc == 17) begin tag = "R8"; return m64 ? 4'd6 : 4'd0; end
        if (rc == 7 && str) begin tag = "R5"; return m64 ? 4'd6 : 4'd3; end
        n = 0; o = -1;
        for (int s = 0; s < 4; s++)
            if (pv[s] && ovr_code(pb[8*s +: 8]) >= 0) begin
                n++; o = ovr_code(pb[8*s +: 8]);
            end
        if (n > 1) begin tag = "R3"; return 4'hF; end
        if (n == 1) begin
            if (m64) begin tag = "R10"; return (o == 4 || o == 5) ? 4'(o) : 4'd6; end
            tag = "R2"; return 4'(o);
        end
        if (m64) begin tag = "R10"; return 4'd6; end
        case (rc)
            0, 1, 2: begin tag = "R9"; return (asz == 0) ? 4'hF : 4'd2; end
            3, 6, 7, 16: begin tag = "R6"; return 4'd2; end
            4, 5: begin tag = "R7"; return 4'd1; end
            default: begin tag = "R11"; return 4'hF; end
        endcase
    endfunction

    task automatic drive(input logic [31:0] pb, input logic [3:0] pv, input logic [7:0] opc,
                         input logic one, input int rc, input int asz, input logic m64,
                         input string force_tag);
        string t;
        logic [3:0] e;
        @(negedge clk);
        pfx_bytes = pb; pfx_valid = pv; opcode = opc; opcode_single = one;
        op_reg = 5'(rc); addr_size = 2'(asz); mode64 = m64;
        e = model(pb, pv, opc, one, rc, asz, m64, t);
        if (force_tag != "") t = force_tag;
        exp_q.push_back(e);
        tag_q.push_back(t);
    endtask

    // monitor: compares one clock after each drive (R1 latency)
    always begin
        @(posedge clk);
        #2;
        if (exp_q.size() > 0) begin
            logic [3:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if ({seg_err, seg_idx} !== e) begin
                failures++;
                $display("FAIL %s: got err=%0b idx=%0d, expected err=%0b idx=%0d",
                         t, seg_err, seg_idx, e[3], e[2:0]);
            end
        end
    end

    function automatic void build_pfx(input int cfg, output logic [31:0] pb,
                                      output logic [3:0] pv);
        logic [7:0] ovr [6] = '{8'h2E, 8'h36, 8'h3E, 8'h26, 8'h64, 8'h65};
        pb = {8'h66, 8'hF3, 8'hF0, 8'h67};
        pv = 4'b0000;
        case (cfg)
            0: pv = 4'b0000;
            1, 2, 3, 4, 5, 6: begin
                pb[8*(cfg%4) +: 8] = ovr[cfg-1];
                pv = 4'b1111;
            end
            7: begin pb[7:0] = 8'h64; pb[23:16] = 8'h2E; pv = 4'b0101; end
            8: begin pb[7:0] = 8'h26; pb[15:8] = 8'hF3; pb[23:16] = 8'h65; pv = 4'b0110; end
            default: begin pb[15:8] = 8'h36; pb[31:24] = 8'h36; pv = 4'b1010; end
        endcase
    endfunction

    initial begin
        #(CLK_P * 150000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] opcs [3] = '{8'hA4, 8'hA4, 8'h8B};
        logic       ones [3] = '{1'b1, 1'b0, 1'b1};
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        checks++;
        if (seg_idx !== 3'd6 || seg_err !== 1'b0) begin
            failures++;
            $display("FAIL R1: got err=%0b idx=%0d, expected err=0 idx=6", seg_err, seg_idx);
        end
        rst = 1'b0;

        // directed boundary cases
        drive(32'h0000_2E64, 4'b0011, 8'hAB, 1'b1, 7, 0, 1'b0, "R5");   // string DI ignores 2 overrides
        drive(32'h0000_2E64, 4'b0011, 8'h90, 1'b1, 17, 0, 1'b0, "R8");  // IP skips prefixes
        drive(32'h0000_0026, 4'b0001, 8'h90, 1'b1, 0, 0, 1'b0, "R9");   // override rescues 16-bit A
        drive(32'h0000_0000, 4'b0000, 8'h6C, 1'b1, 7, 1, 1'b0, "R5");
        drive(32'h0000_0000, 4'b0000, 8'h70, 1'b1, 7, 1, 1'b0, "R6");
        drive(32'h0000_0000, 4'b0000, 8'hA8, 1'b1, 7, 1, 1'b0, "R6");
        drive(32'h0000_0000, 4'b0000, 8'hAF, 1'b1, 7, 1, 1'b0, "R5");
        drive(32'h0000_0065, 4'b0001, 8'h90, 1'b1, 3, 2, 1'b1, "R10");
        drive(32'h0000_003E, 4'b0001, 8'h90, 1'b1, 3, 2, 1'b1, "R10");

        // full sweep
        for (int rc = 0; rc < 32; rc++)
            for (int m = 0; m < 2; m++)
                for (int a = 0; a < 3; a++)
                    for (int oc = 0; oc < 3; oc++)
                        for (int cfg = 0; cfg < 10; cfg++) begin
                            logic [31:0] pb;
                            logic [3:0]  pv;
                            build_pfx(cfg, pb, pv);
                            drive(pb, pv, opcs[oc], ones[oc], rc, a, m[0],
                                  (cfg == 8 && rc != 17 && !(rc == 7 && oc == 0)) ? "R4" : "");
                        end

        @(posedge clk);
        #4;
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule